// File: doc/BRIEF.md
# Effective Address Generator

This block computes the memory address for a load or store in a 32-bit RISC pipeline. From a two-bit mode select, a two-bit operand size, an 8-bit displacement taken from the instruction and four register values (general register Rn, index register R0, a global base register and the program counter), it forms one 32-bit effective address. It also flags a combination that is not allowed and an address that does not suit the access size.

Four modes are supported: register plus index, base plus scaled displacement, base plus index, and PC-relative. Displacements are always treated as unsigned. The displacement is scaled by the operand size. PC-relative longword accesses first round the PC down to a multiple of four. A parameter chooses between a purely combinational result and one registered output stage. The register file, the memory access, decoding and any register update are handled elsewhere.

Top module: `eag_unit`

## Requirements
- R1: With mode 2'b00 (register indexed), the address is Rn + R0, and the operand size does not scale it.
- R2: With mode 2'b01 (base plus displacement), the 8-bit displacement is zero-extended, so a field of 8'hFF adds 255 and never subtracts.
- R3: In mode 2'b01 the displacement is multiplied by 1, 2 or 4 for size 2'b00 (byte), 2'b01 (word) or 2'b10 (longword) before it is added to the global base register.
- R4: With mode 2'b10 (base indexed), the address is global base + R0, with no scaling for any legal size.
- R5: With mode 2'b11 (PC-relative) and word size, the address is PC + displacement*2, and the PC is used unmasked.
- R6: With mode 2'b11 and longword size, the address is (PC AND 32'hFFFFFFFC) + displacement*4.
- R7: Size 2'b11 in any mode, or byte size in mode 2'b11, sets `illegal` to 1 and forces `ea` to zero and `misaligned` to 0.
- R8: `misaligned` is 1 when a word access yields an address with bit 0 set, or a longword access yields an address with bit 1 or bit 0 set. A byte access never sets it.
- R9: All sums wrap modulo 2^32 and raise no indication of overflow.
- R10: With REG_OUT=1 (the default), the result of a cycle with `in_valid` high appears on the outputs after the next rising clock edge, with `out_valid` high. A cycle with `in_valid` low drives `out_valid` low and leaves `ea`, `misaligned` and `illegal` unchanged. A synchronous reset `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Inputs carry a request this cycle |
| mode | input | 2 | Addressing mode select |
| size | input | 2 | Operand size: byte, word, longword, reserved |
| disp | input | 8 | Unsigned displacement field |
| rn | input | 32 | General register operand |
| r0 | input | 32 | Index register operand |
| gbr | input | 32 | Global base register value |
| pc | input | 32 | Program counter value |
| out_valid | output | 1 | Output carries a result |
| ea | output | 32 | Effective address |
| misaligned | output | 1 | Address does not suit the access size |
| illegal | output | 1 | Mode and size combination is not allowed |

## Verification
The hardest situation to reach is the one where a flag depends on the sum rather than on any single operand. Examples are a longword PC-relative result whose PC has low bits set, which must still come out aligned, and a word PC-relative result from the same odd PC, which must come out misaligned. The stimulus holds the PC at an odd value and switches only the size between two requests. It also feeds operands whose sum crosses 2^32 and a displacement of all ones, so that wrap-around and zero extension show up in the address.

// File: rtl/eag_pkg.sv
package eag_pkg;

   typedef enum logic [1:0] {
      EA_IDX_REG   = 2'b00,
      EA_BASE_DISP = 2'b01,
      EA_BASE_IDX  = 2'b10,
      EA_PC_REL    = 2'b11
   } ea_mode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_WORD = 2'b01,
      SZ_LONG = 2'b10,
      SZ_RSVD = 2'b11
   } ea_size_e;

   localparam int unsigned MODE_W = 2;
   localparam int unsigned SIZE_W = 2;

endpackage

// File: rtl/eag_disp_scale.sv
module eag_disp_scale
   import eag_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DISP_W = 8
) (
   input  logic [DISP_W-1:0] disp,
   input  logic [SIZE_W-1:0] size,
   output logic [ADDR_W-1:0] scaled
);
   localparam int unsigned PAD_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] zext;

   assign zext = {{PAD_W{1'b0}}, disp};

   always_comb begin
      unique case (ea_size_e'(size))
         SZ_WORD: scaled = zext << 1;
         SZ_LONG: scaled = zext << 2;
         default: scaled = zext;
      endcase
   end
endmodule

// File: rtl/eag_operand_mux.sv
module eag_operand_mux
   import eag_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [SIZE_W-1:0] size,
   input  logic [ADDR_W-1:0] rn,
   input  logic [ADDR_W-1:0] r0,
   input  logic [ADDR_W-1:0] gbr,
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] disp_scaled,
   output logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] addend,
   output logic              bad_combo
);
   localparam logic [ADDR_W-1:0] WORD4_MASK = ~(ADDR_W'(3));

   ea_mode_e m;
   ea_size_e s;

   assign m = ea_mode_e'(mode);
   assign s = ea_size_e'(size);

   always_comb begin
      base      = rn;
      addend    = r0;
      bad_combo = (s == SZ_RSVD);
      unique case (m)
         EA_IDX_REG: begin
            base   = rn;
            addend = r0;
         end
         EA_BASE_DISP: begin
            base   = gbr;
            addend = disp_scaled;
         end
         EA_BASE_IDX: begin
            base   = gbr;
            addend = r0;
         end
         EA_PC_REL: begin
            base      = (s == SZ_LONG) ? (pc & WORD4_MASK) : pc;
            addend    = disp_scaled;
            bad_combo = (s == SZ_RSVD) || (s == SZ_BYTE);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/eag_align_check.sv
module eag_align_check
   import eag_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   output logic              misaligned
);
   always_comb begin
      unique case (ea_size_e'(size))
         SZ_WORD: misaligned = addr[0];
         SZ_LONG: misaligned = |addr[1:0];
         default: misaligned = 1'b0;
      endcase
   end
endmodule

// File: rtl/eag_unit.sv
module eag_unit
   import eag_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DISP_W  = 8,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [1:0]        mode,
   input  logic [1:0]        size,
   input  logic [DISP_W-1:0] disp,
   input  logic [ADDR_W-1:0] rn,
   input  logic [ADDR_W-1:0] r0,
   input  logic [ADDR_W-1:0] gbr,
   input  logic [ADDR_W-1:0] pc,
   output logic              out_valid,
   output logic [ADDR_W-1:0] ea,
   output logic              misaligned,
   output logic              illegal
);
   if (ADDR_W < DISP_W + 2) begin : g_bad_width
      $error("eag_unit: ADDR_W must leave room for a displacement scaled by 4");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("eag_unit: ADDR_W must be at least 2");
   end

   logic [ADDR_W-1:0] disp_scaled;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] addend;
   logic [ADDR_W-1:0] sum;
   logic [ADDR_W-1:0] ea_c;
   logic              bad_c;
   logic              mis_c;

   eag_disp_scale #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_scale (
      .disp   (disp),
      .size   (size),
      .scaled (disp_scaled)
   );

   eag_operand_mux #(.ADDR_W(ADDR_W)) u_mux (
      .mode        (mode),
      .size        (size),
      .rn          (rn),
      .r0          (r0),
      .gbr         (gbr),
      .pc          (pc),
      .disp_scaled (disp_scaled),
      .base        (base),
      .addend      (addend),
      .bad_combo   (bad_c)
   );

   assign sum  = base + addend;
   assign ea_c = bad_c ? '0 : sum;

   eag_align_check #(.ADDR_W(ADDR_W)) u_align (
      .addr       (ea_c),
      .size       (size),
      .misaligned (mis_c)
   );

   if (REG_OUT) begin : g_reg_out
      logic [ADDR_W-1:0] ea_q;
      logic              mis_q;
      logic              bad_q;
      logic              vld_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            vld_q <= 1'b0;
         end else begin
            vld_q <= in_valid;
         end
         if (in_valid) begin
            ea_q  <= ea_c;
            mis_q <= mis_c;
            bad_q <= bad_c;
         end
      end

      assign out_valid  = vld_q;
      assign ea         = ea_q;
      assign misaligned = mis_q;
      assign illegal    = bad_q;
   end else begin : g_comb_out
      assign out_valid  = in_valid;
      assign ea         = ea_c;
      assign misaligned = mis_c;
      assign illegal    = bad_c;
   end
endmodule

// File: rtl/eag_unit_checker.sv
module eag_unit_checker #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DISP_W  = 8,
   parameter bit          REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [1:0]        mode,
   input logic [1:0]        size,
   input logic [DISP_W-1:0] disp,
   input logic [ADDR_W-1:0] rn,
   input logic [ADDR_W-1:0] r0,
   input logic [ADDR_W-1:0] gbr,
   input logic [ADDR_W-1:0] pc,
   input logic              out_valid,
   input logic [ADDR_W-1:0] ea,
   input logic              misaligned,
   input logic              illegal
);
   logic [1:0] seen_size;
   logic [1:0] seen_mode;

   if (REG_OUT) begin : g_track
      logic [1:0] size_q;
      logic [1:0] mode_q;
      always_ff @(posedge clk) begin
         if (in_valid) begin
            size_q <= size;
            mode_q <= mode;
         end
      end
      assign seen_size = size_q;
      assign seen_mode = mode_q;

      // R10: a request is answered on the following cycle
      a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> out_valid);
      // R10: reset empties the output stage
      a_r10_reset_clears: assert property (@(posedge clk)
         rst |=> !out_valid);
   end else begin : g_track_comb
      assign seen_size = size;
      assign seen_mode = mode;
   end

   // R7: a rejected combination never yields an address
   a_r7_illegal_zero: assert property (@(posedge clk) disable iff (rst)
      (out_valid && illegal) |-> (ea == '0 && !misaligned));

   // R8: byte accesses are never flagged
   a_r8_byte_aligned: assert property (@(posedge clk) disable iff (rst)
      (out_valid && seen_size == 2'b00) |-> !misaligned);

   // R8: longword flag tracks the low address bits
   a_r8_long_flag: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !illegal && seen_size == 2'b10) |-> (misaligned == (ea[1:0] != 2'b00)));

   // R6: PC-relative longword result is always 4-byte aligned
   a_r6_pc_long_aligned: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !illegal && seen_mode == 2'b11 && seen_size == 2'b10) |-> (ea[1:0] == 2'b00));
endmodule

bind eag_unit eag_unit_checker #(
   .ADDR_W(ADDR_W), .DISP_W(DISP_W), .REG_OUT(REG_OUT)
) u_eag_unit_checker (
   .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .size(size),
   .disp(disp), .rn(rn), .r0(r0), .gbr(gbr), .pc(pc),
   .out_valid(out_valid), .ea(ea), .misaligned(misaligned), .illegal(illegal)
);

// File: tb/eag_unit_bench.sv
module eag_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 5000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [1:0]  size = 2'b00;
   logic [7:0]  disp = 8'h00;
   logic [31:0] rn = '0, r0 = '0, gbr = '0, pc = '0;
   logic        out_valid;
   logic [31:0] ea;
   logic        misaligned;
   logic        illegal;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eag_unit u_eag_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .size(size),
      .disp(disp), .rn(rn), .r0(r0), .gbr(gbr), .pc(pc),
      .out_valid(out_valid), .ea(ea), .misaligned(misaligned), .illegal(illegal)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   // Drive one request, let the output stage capture it, sample mid-cycle.
   task automatic issue(input logic [1:0] m, input logic [1:0] s, input logic [7:0] d,
                        input logic [31:0] a_rn, input logic [31:0] a_r0,
                        input logic [31:0] a_gbr, input logic [31:0] a_pc);
      @(negedge clk);
      in_valid = 1'b1; mode = m; size = s; disp = d;
      rn = a_rn; r0 = a_r0; gbr = a_gbr; pc = a_pc;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_out(input string tag, input logic [31:0] e_ea,
                             input logic e_mis, input logic e_bad);
      check(tag, "out_valid", 32'(out_valid), 32'd1);
      check(tag, "ea", ea, e_ea);
      check(tag, "misaligned", 32'(misaligned), 32'(e_mis));
      check(tag, "illegal", 32'(illegal), 32'(e_bad));
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check("R10", "out_valid in reset", 32'(out_valid), 32'd0);
      rst = 1'b0;
   endtask

   task automatic t_r1_indexed();
      issue(2'b00, 2'b10, 8'hFF, 32'h0000_1000, 32'h0000_0024, 32'h9999_0000, 32'h0);
      expect_out("R1", 32'h0000_1024, 1'b0, 1'b0);
      issue(2'b00, 2'b01, 8'h00, 32'h0000_1001, 32'h0000_0000, 32'h0, 32'h0);
      expect_out("R8", 32'h0000_1001, 1'b1, 1'b0);
   endtask

   task automatic t_r2_r3_disp();
      issue(2'b01, 2'b00, 8'hFF, 32'h0, 32'h0, 32'h0000_2000, 32'h0);
      expect_out("R2", 32'h0000_20FF, 1'b0, 1'b0);
      issue(2'b01, 2'b01, 8'hFF, 32'h0, 32'h0, 32'h0000_2000, 32'h0);
      expect_out("R3", 32'h0000_21FE, 1'b0, 1'b0);
      issue(2'b01, 2'b10, 8'hFF, 32'h0, 32'h0, 32'h0000_2000, 32'h0);
      expect_out("R3", 32'h0000_23FC, 1'b0, 1'b0);
   endtask

   task automatic t_r4_base_idx();
      issue(2'b10, 2'b10, 8'h40, 32'h5555_0000, 32'h0000_0081, 32'h0000_3000, 32'h0);
      expect_out("R4", 32'h0000_3081, 1'b1, 1'b0);
      issue(2'b10, 2'b00, 8'h40, 32'h0, 32'h0000_0003, 32'h0000_3000, 32'h0);
      expect_out("R4", 32'h0000_3003, 1'b0, 1'b0);
   endtask

   task automatic t_r5_r6_pc();
      issue(2'b11, 2'b01, 8'h10, 32'h0, 32'h0, 32'h0, 32'h0000_4003);
      expect_out("R5", 32'h0000_4023, 1'b1, 1'b0);
      issue(2'b11, 2'b10, 8'h10, 32'h0, 32'h0, 32'h0, 32'h0000_4003);
      expect_out("R6", 32'h0000_4040, 1'b0, 1'b0);
   endtask

   task automatic t_r7_illegal();
      issue(2'b00, 2'b11, 8'h00, 32'h0000_1000, 32'h0000_0001, 32'h0, 32'h0);
      expect_out("R7", 32'h0, 1'b0, 1'b1);
      issue(2'b11, 2'b00, 8'h10, 32'h0, 32'h0, 32'h0, 32'h0000_4001);
      expect_out("R7", 32'h0, 1'b0, 1'b1);
   endtask

   task automatic t_r9_wrap();
      issue(2'b00, 2'b10, 8'h00, 32'hFFFF_FFF0, 32'h0000_0020, 32'h0, 32'h0);
      expect_out("R9", 32'h0000_0010, 1'b0, 1'b0);
      issue(2'b01, 2'b10, 8'h04, 32'h0, 32'h0, 32'hFFFF_FFFC, 32'h0);
      expect_out("R9", 32'h0000_000C, 1'b0, 1'b0);
   endtask

   task automatic t_r10_hold_and_reset();
      issue(2'b00, 2'b01, 8'h00, 32'h0000_0101, 32'h0, 32'h0, 32'h0);
      expect_out("R10", 32'h0000_0101, 1'b1, 1'b0);
      // idle cycle with different operands: outputs must not move
      mode = 2'b11; size = 2'b11; rn = 32'hDEAD_0000;
      @(negedge clk);
      check("R10", "out_valid idle", 32'(out_valid), 32'd0);
      check("R10", "ea held", ea, 32'h0000_0101);
      check("R10", "misaligned held", 32'(misaligned), 32'd1);
      check("R10", "illegal held", 32'(illegal), 32'd0);
      // reset while a request is presented
      in_valid = 1'b1; mode = 2'b00; size = 2'b00; rst = 1'b1;
      @(negedge clk);
      check("R10", "out_valid under reset", 32'(out_valid), 32'd0);
      rst = 1'b0; in_valid = 1'b0;
   endtask

   initial begin
      t_reset();
      t_r1_indexed();
      t_r2_r3_disp();
      t_r4_base_idx();
      t_r5_r6_pc();
      t_r7_illegal();
      t_r9_wrap();
      t_r10_hold_and_reset();
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < WATCHDOG_CYCLES; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule